// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks a vector operation element by element. It keeps two element positions, one on the operand (source) side and one on the result (destination) side. Each side has its own predicate mask. When a side is in skip mode, its position moves past every element whose mask bit is clear. Skipping costs one clock per passed element. When a side is in zeroing mode, clear elements are not passed over. A clear source element is issued with zero operands and no register read. A clear destination element is computed, but the value stored for it is zero and its condition code is the equal-to-zero code.

For each source/destination pair it issues one request to an external execution unit. It then holds a ready signal until the unit returns a result and a condition code. The sequencer optionally forces that result to zero and presents it with a write strobe for the destination position. The condition code has its own strobe, which fires only when the record-condition flag was given. After each writeback both positions step forward by one. The operation ends, with a single-cycle done pulse, as soon as either position reaches the vector length.

All configuration inputs are captured on the start pulse. A run is started with one start pulse and then needs no further control.

Top module: `pred_elem_seq`

## Requirements
- R1: With source zeroing off, elements are issued only at source positions whose mask bit (bit n of the source mask for position n) is set. `rd_src_idx` gives that position and `rd_req` is high for it.
- R2: With destination zeroing off, results are written only at destination positions whose mask bit is set. `wb_idx` gives that position.
- R3: The two positions skip independently. After each writeback both increase by one, so the k-th issued source position is paired with the k-th written destination position.
- R4: With source zeroing on, a clear source position is not skipped. It is issued with `op_zero`=1 and `rd_req`=0.
- R5: With destination zeroing on, a clear destination position is still written. `wb_data` is 0 and `cr_val` is the equal-to-zero code. Condition codes are 3 bits: less-than = 3'b100, greater-than = 3'b010, equal-to-zero = 3'b001.
- R6: `wb_en` fires once for every processed element. `cr_en` fires together with it only when the record-condition flag was set at start.
- R7: `done` is a one-cycle pulse, given when either position reaches the vector length. A vector length of 0 gives `done` in the cycle after start, with no issue and no write strobe.
- R8: Each skipped position costs one clock. With both masks all clear and no zeroing, `done` is seen VL+2 cycles after start is driven (VL+1 edges after the edge that samples start).
- R9: After an issue, `res_ready` stays high until `res_valid` is seen. Each element holds `res_ready` for exactly as many cycles as the unit delays, plus one. No write strobe appears before the result is accepted.
- R10: Length, masks and flags are captured at start. Changes to them, and further start pulses during a run, have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| vec_len | input | IW | Vector length, IW = clog2(MAXVL+1) |
| src_mask | input | MAXVL | Source predicate, bit n for position n |
| dst_mask | input | MAXVL | Destination predicate |
| src_zero | input | 1 | Source zeroing mode |
| dst_zero | input | 1 | Destination zeroing mode |
| rec_cr | input | 1 | Record-condition flag |
| busy | output | 1 | Run in progress |
| iss_valid | output | 1 | Element issue to execution unit |
| rd_req | output | 1 | Operand register read request |
| op_zero | output | 1 | Operands are forced to zero |
| rd_src_idx | output | IW | Current source position |
| res_ready | output | 1 | Waiting for a result |
| res_valid | input | 1 | Result present |
| res_data | input | DATAW | Result value |
| res_cr | input | 3 | Result condition code |
| wb_en | output | 1 | Result write strobe |
| wb_idx | output | IW | Destination position written |
| wb_data | output | DATAW | Value written |
| cr_en | output | 1 | Condition write strobe |
| cr_val | output | 3 | Condition value written |
| done | output | 1 | End-of-run pulse |

## Verification
The bench targets masks that differ between the two sides. A design that reused one mask for both sides, or that stepped the sides in lockstep, would write to the wrong destination positions. Zeroing is tested on each side alone and on both together. An inverted test would either skip an element that should be zeroed, or force a result that should have been kept. Masks whose set bits lie beyond the vector length, a length of zero, and an all-clear walk with a measured cycle count expose a missing end bound, an extra strobe, or a skip that takes more or less than one clock. Inputs are scrambled and start is pulsed again mid-run, which exposes a design that reads live inputs instead of its captured copy.

// File: rtl/pes_pkg.sv
package pes_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SKIP  = 3'd1,
      ST_ISSUE = 3'd2,
      ST_EXEC  = 3'd3,
      ST_WB    = 3'd4
   } pes_state_e;

   localparam int CRW = 3;
   localparam logic [CRW-1:0] CR_LT = 3'b100;
   localparam logic [CRW-1:0] CR_GT = 3'b010;
   localparam logic [CRW-1:0] CR_EQ = 3'b001;
endpackage

// File: rtl/pes_step_unit.sv
// One element position with predicate-driven skipping.
module pes_step_unit #(
   parameter int MAXVL = 16,
   parameter int IW    = $clog2(MAXVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             skip_en,
   input  logic             inc,
   input  logic [MAXVL-1:0] mask,
   input  logic             zero_en,
   input  logic [IW-1:0]    vl,
   output logic [IW-1:0]    idx,
   output logic             at_end,
   output logic             bit_set,
   output logic             want_skip
);
   localparam logic [MAXVL-1:0] ONE = MAXVL'(1);

   // position bit selected by shifting a one left by the position
   assign bit_set   = |(mask & (ONE << idx));
   assign at_end    = (idx == vl);
   assign want_skip = !zero_en && !bit_set && !at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (clr)
         idx <= '0;
      else if ((skip_en && want_skip) || inc)
         idx <= idx + IW'(1);
   end
endmodule

// File: rtl/pes_result_gate.sv
// Forces result and condition to the zero form when requested.
module pes_result_gate
   import pes_pkg::*;
#(
   parameter int DATAW = 32
) (
   input  logic             force_zero,
   input  logic [DATAW-1:0] d_in,
   input  logic [CRW-1:0]   cr_in,
   output logic [DATAW-1:0] d_out,
   output logic [CRW-1:0]   cr_out
);
   always_comb begin
      if (force_zero) begin
         d_out  = '0;
         cr_out = CR_EQ;
      end else begin
         d_out  = d_in;
         cr_out = cr_in;
      end
   end
endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
   import pes_pkg::*;
#(
   parameter int MAXVL = 16,
   parameter int DATAW = 32,
   parameter int IW    = $clog2(MAXVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IW-1:0]    vec_len,
   input  logic [MAXVL-1:0] src_mask,
   input  logic [MAXVL-1:0] dst_mask,
   input  logic             src_zero,
   input  logic             dst_zero,
   input  logic             rec_cr,
   output logic             busy,
   output logic             iss_valid,
   output logic             rd_req,
   output logic             op_zero,
   output logic [IW-1:0]    rd_src_idx,
   output logic             res_ready,
   input  logic             res_valid,
   input  logic [DATAW-1:0] res_data,
   input  logic [CRW-1:0]   res_cr,
   output logic             wb_en,
   output logic [IW-1:0]    wb_idx,
   output logic [DATAW-1:0] wb_data,
   output logic             cr_en,
   output logic [CRW-1:0]   cr_val,
   output logic             done
);
   localparam int NSIDE = 2;

   if (MAXVL < 1) begin : g_bad_maxvl
      $error("pred_elem_seq: MAXVL must be at least 1");
   end
   if (DATAW < 1) begin : g_bad_dataw
      $error("pred_elem_seq: DATAW must be at least 1");
   end
   if (IW < $clog2(MAXVL + 1)) begin : g_bad_iw
      $error("pred_elem_seq: IW too narrow for MAXVL");
   end

   pes_state_e state, state_nx;

   // configuration captured at start
   logic [IW-1:0]    cfg_vl;
   logic [MAXVL-1:0] cfg_smask, cfg_dmask;
   logic             cfg_sz, cfg_dz, cfg_rc;

   logic launch;
   assign launch = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_vl    <= '0;
         cfg_smask <= '0;
         cfg_dmask <= '0;
         cfg_sz    <= 1'b0;
         cfg_dz    <= 1'b0;
         cfg_rc    <= 1'b0;
      end else if (launch) begin
         cfg_vl    <= vec_len;
         cfg_smask <= src_mask;
         cfg_dmask <= dst_mask;
         cfg_sz    <= src_zero;
         cfg_dz    <= dst_zero;
         cfg_rc    <= rec_cr;
      end
   end

   // per-side position units: index 0 is source, index 1 is destination
   logic [MAXVL-1:0] side_mask [NSIDE];
   logic             side_zero [NSIDE];
   logic [IW-1:0]    side_idx  [NSIDE];
   logic             side_end  [NSIDE];
   logic             side_bit  [NSIDE];
   logic             side_want [NSIDE];

   assign side_mask[0] = cfg_smask;
   assign side_mask[1] = cfg_dmask;
   assign side_zero[0] = cfg_sz;
   assign side_zero[1] = cfg_dz;

   logic finish, any_skip, skip_en, inc;
   assign finish   = side_end[0] || side_end[1];
   assign any_skip = side_want[0] || side_want[1];
   assign skip_en  = (state == ST_SKIP) && !finish;
   assign inc      = (state == ST_WB);

   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      pes_step_unit #(
         .MAXVL (MAXVL),
         .IW    (IW)
      ) u_step (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (launch),
         .skip_en   (skip_en),
         .inc       (inc),
         .mask      (side_mask[g]),
         .zero_en   (side_zero[g]),
         .vl        (cfg_vl),
         .idx       (side_idx[g]),
         .at_end    (side_end[g]),
         .bit_set   (side_bit[g]),
         .want_skip (side_want[g])
      );
   end

   logic [IW-1:0] s_idx, d_idx;
   assign s_idx = side_idx[0];
   assign d_idx = side_idx[1];

   // control FSM
   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start && vec_len != '0) state_nx = ST_SKIP;
         ST_SKIP: begin
            if (finish)        state_nx = ST_IDLE;
            else if (!any_skip) state_nx = ST_ISSUE;
         end
         ST_ISSUE: state_nx = ST_EXEC;
         ST_EXEC:  if (res_valid) state_nx = ST_WB;
         ST_WB:    state_nx = ST_SKIP;
         default:  state_nx = ST_IDLE;
      endcase
   end

   logic done_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         state  <= state_nx;
         done_q <= (launch && vec_len == '0) || ((state == ST_SKIP) && finish);
      end
   end

   // result path
   logic [DATAW-1:0] gated_d;
   logic [CRW-1:0]   gated_cr;
   logic             dst_force;
   assign dst_force = cfg_dz && !side_bit[1];

   pes_result_gate #(.DATAW(DATAW)) u_gate (
      .force_zero (dst_force),
      .d_in       (res_data),
      .cr_in      (res_cr),
      .d_out      (gated_d),
      .cr_out     (gated_cr)
   );

   logic [DATAW-1:0] wb_data_q;
   logic [CRW-1:0]   cr_q;
   logic [IW-1:0]    wb_idx_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_data_q <= '0;
         cr_q      <= '0;
         wb_idx_q  <= '0;
      end else if ((state == ST_EXEC) && res_valid) begin
         wb_data_q <= gated_d;
         cr_q      <= gated_cr;
         wb_idx_q  <= d_idx;
      end
   end

   logic src_force;
   assign src_force = cfg_sz && !side_bit[0];

   assign busy       = (state != ST_IDLE);
   assign iss_valid  = (state == ST_ISSUE);
   assign op_zero    = iss_valid && src_force;
   assign rd_req     = iss_valid && !src_force;
   assign rd_src_idx = s_idx;
   assign res_ready  = (state == ST_EXEC);
   assign wb_en      = (state == ST_WB);
   assign cr_en      = wb_en && cfg_rc;
   assign wb_idx     = wb_idx_q;
   assign wb_data    = wb_data_q;
   assign cr_val     = cr_q;
   assign done       = done_q;
endmodule

// File: rtl/pes_seq_checker.sv
module pes_seq_checker #(
   parameter int MAXVL = 16,
   parameter int DATAW = 32,
   parameter int IW    = $clog2(MAXVL + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic             rd_req,
   input logic             op_zero,
   input logic [IW-1:0]    rd_src_idx,
   input logic             res_ready,
   input logic             res_valid,
   input logic             wb_en,
   input logic [IW-1:0]    wb_idx,
   input logic [DATAW-1:0] wb_data,
   input logic             cr_en,
   input logic [2:0]       cr_val,
   input logic             done,
   input logic [MAXVL-1:0] cfg_smask,
   input logic [MAXVL-1:0] cfg_dmask,
   input logic             cfg_sz,
   input logic             cfg_dz,
   input logic             cfg_rc
);
   localparam logic [MAXVL-1:0] ONE = MAXVL'(1);

   logic sbit, dbit;
   assign sbit = |(cfg_smask & (ONE << rd_src_idx));
   assign dbit = |(cfg_dmask & (ONE << wb_idx));

   // R1
   a_r1_read_on_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && rd_req) |-> sbit);
   // R2
   a_r2_write_on_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (dbit || cfg_dz));
   // R3
   a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iss_valid, wb_en, done}));
   // R4
   a_r4_zero_operands_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && op_zero) |-> (!rd_req && cfg_sz && !sbit));
   // R5
   a_r5_forced_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !dbit) |-> (wb_data == '0 && cr_val == 3'b001));
   // R6
   a_r6_cr_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cr_en |-> (wb_en && cfg_rc));
   a_r6_cr_strobe_present: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && cfg_rc) |-> cr_en);
   // R7
   a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   a_r9_write_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(res_valid && res_ready));
endmodule

bind pred_elem_seq pes_seq_checker #(
   .MAXVL (MAXVL),
   .DATAW (DATAW),
   .IW    (IW)
) u_pes_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_valid  (iss_valid),
   .rd_req     (rd_req),
   .op_zero    (op_zero),
   .rd_src_idx (rd_src_idx),
   .res_ready  (res_ready),
   .res_valid  (res_valid),
   .wb_en      (wb_en),
   .wb_idx     (wb_idx),
   .wb_data    (wb_data),
   .cr_en      (cr_en),
   .cr_val     (cr_val),
   .done       (done),
   .cfg_smask  (cfg_smask),
   .cfg_dmask  (cfg_dmask),
   .cfg_sz     (cfg_sz),
   .cfg_dz     (cfg_dz),
   .cfg_rc     (cfg_rc)
);

// File: tb/pred_elem_seq_test.sv
module pred_elem_seq_test;
   localparam int MAXVL = 16;
   localparam int DATAW = 32;
   localparam int IW    = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [IW-1:0]    vec_len = '0;
   logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
   logic             src_zero = 1'b0, dst_zero = 1'b0, rec_cr = 1'b0;
   logic             busy, iss_valid, rd_req, op_zero, res_ready;
   logic [IW-1:0]    rd_src_idx, wb_idx;
   logic             res_valid = 1'b0;
   logic [DATAW-1:0] res_data = '0, wb_data;
   logic [2:0]       res_cr = '0, cr_val;
   logic             wb_en, cr_en, done;

   always #4 clk = ~clk;

   pred_elem_seq #(.MAXVL(MAXVL), .DATAW(DATAW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
      .src_mask(src_mask), .dst_mask(dst_mask), .src_zero(src_zero),
      .dst_zero(dst_zero), .rec_cr(rec_cr), .busy(busy),
      .iss_valid(iss_valid), .rd_req(rd_req), .op_zero(op_zero),
      .rd_src_idx(rd_src_idx), .res_ready(res_ready), .res_valid(res_valid),
      .res_data(res_data), .res_cr(res_cr), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_data(wb_data), .cr_en(cr_en), .cr_val(cr_val), .done(done)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [4:0]  vl;
      logic [15:0] sm;
      logic [15:0] dm;
      logic        sz;
      logic        dz;
      logic        rc;
      logic [1:0]  lat;
   } case_t;

   localparam int NCASE = 8;
   localparam case_t CASES [NCASE] = '{
      '{5'd8,  16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b1, 2'd0},  // R1 R2 dense
      '{5'd8,  16'h00A5, 16'h003C, 1'b0, 1'b0, 1'b1, 2'd1},  // R3 different masks
      '{5'd16, 16'h00F0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'd2},  // R6 no cr, R9 delay
      '{5'd8,  16'h0055, 16'h00FF, 1'b1, 1'b0, 1'b1, 2'd0},  // R4 source zeroing
      '{5'd8,  16'h00FF, 16'h000F, 1'b0, 1'b1, 1'b1, 2'd1},  // R5 dest zeroing
      '{5'd6,  16'h0024, 16'h0015, 1'b1, 1'b1, 1'b1, 2'd1},  // R4 R5 both
      '{5'd5,  16'h0080, 16'h00FF, 1'b0, 1'b0, 1'b1, 2'd0},  // R1 bits past VL
      '{5'd16, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 1'b1, 2'd2}   // R3 dst far ahead
   };

   int exp_s [32];
   int exp_d [32];
   int exp_n;

   function automatic bit mbit(input logic [15:0] m, input int i);
      return (i < 16) ? m[i] : 1'b0;
   endfunction

   task automatic model(input case_t c);
      int s = 0, d = 0, vl = int'(c.vl);
      exp_n = 0;
      forever begin
         if (!c.sz) while (s != vl && !mbit(c.sm, s)) s++;
         if (!c.dz) while (d != vl && !mbit(c.dm, d)) d++;
         if (s == vl || d == vl) break;
         exp_s[exp_n] = s;
         exp_d[exp_n] = d;
         exp_n++;
         s++;
         d++;
      end
   endtask

   task automatic run_case(input case_t c, input bit poke, input string tag,
                           output int cyc);
      int got = 0, wait_ctr = 0, ready_cnt = 0, issued = 0;
      bit fin = 0, acc = 0, pend = 0, pend_zero = 0, clr_start = 0;
      int pend_idx = 0;
      model(c);
      @(negedge clk);
      vec_len = c.vl; src_mask = c.sm; dst_mask = c.dm;
      src_zero = c.sz; dst_zero = c.dz; rec_cr = c.rc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R10: scramble the live inputs once the run has begun
      vec_len = ~c.vl; src_mask = ~c.sm; dst_mask = ~c.dm;
      src_zero = ~c.sz; dst_zero = ~c.dz; rec_cr = ~c.rc;
      cyc = 1;
      while (!fin && cyc < 400) begin
         if (clr_start) begin start = 1'b0; clr_start = 0; end
         if (acc) begin res_valid = 1'b0; acc = 0; end
         if (res_ready) ready_cnt++;
         if (iss_valid) begin
            if (issued < exp_n) begin
               bit zed = c.sz && !mbit(c.sm, exp_s[issued]);
               check(int'(rd_src_idx) == exp_s[issued], "R1", {tag, " source position"},
                     rd_src_idx, exp_s[issued]);
               check(rd_req == !zed && op_zero == zed, "R4", {tag, " read/zero flags"},
                     {rd_req, op_zero}, {!zed, zed});
            end else
               check(0, "R1", {tag, " unexpected issue"}, issued, exp_n);
            issued++;
            pend = 1; wait_ctr = int'(c.lat);
            pend_zero = op_zero; pend_idx = int'(rd_src_idx);
            if (poke) begin start = 1'b1; clr_start = 1; end
         end
         if (pend && !res_valid && !iss_valid) begin
            if (wait_ctr == 0) begin
               res_valid = 1'b1;
               res_data  = 32'h1000 + (pend_zero ? 0 : pend_idx + 1);
               res_cr    = 3'b100;
               pend = 0;
            end else wait_ctr--;
         end else if (pend && iss_valid && c.lat == 0) begin
            res_valid = 1'b1;
            res_data  = 32'h1000 + (pend_zero ? 0 : pend_idx + 1);
            res_cr    = 3'b100;
            pend = 0;
         end
         if (res_valid && res_ready) acc = 1;
         if (wb_en) begin
            if (got < exp_n) begin
               bit szd = c.sz && !mbit(c.sm, exp_s[got]);
               bit dzd = c.dz && !mbit(c.dm, exp_d[got]);
               logic [31:0] ed = dzd ? 32'h0 : 32'h1000 + (szd ? 0 : exp_s[got] + 1);
               logic [2:0]  ec = dzd ? 3'b001 : 3'b100;
               check(int'(wb_idx) == exp_d[got], "R2", {tag, " dest position"},
                     wb_idx, exp_d[got]);
               check(wb_data == ed, "R5", {tag, " written value"}, wb_data, ed);
               check(cr_en == c.rc, "R6", {tag, " cr strobe"}, cr_en, c.rc);
               if (c.rc) check(cr_val == ec, "R5", {tag, " cr value"}, cr_val, ec);
            end else
               check(0, "R6", {tag, " extra write"}, got, exp_n);
            got++;
         end
         if (done) fin = 1;
         else begin @(negedge clk); cyc++; end
      end
      start = 1'b0;
      check(fin, "R7", {tag, " done seen"}, fin, 1);
      check(got == exp_n, "R3", {tag, " element count"}, got, exp_n);
      check(ready_cnt == exp_n * (int'(c.lat) + 1), "R9", {tag, " ready cycles"},
            ready_cnt, exp_n * (int'(c.lat) + 1));
      @(negedge clk);
      check(!done && !busy, "R7", {tag, " done one cycle, idle after"}, {done, busy}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // reset state
      check(!busy && !iss_valid && !wb_en && !cr_en && !done && !res_ready,
            "R7", "reset outputs quiet",
            {busy, iss_valid, wb_en, cr_en, done, res_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NCASE; i++)
         run_case(CASES[i], (i == 1), $sformatf("case%0d", i), cyc);

      // R7: zero length
      run_case('{5'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 2'd0}, 0, "vl0", cyc);
      check(cyc == 1, "R7", "vl0 done latency", cyc, 1);

      // R8: one clock per skipped position
      run_case('{5'd4, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0}, 0, "skip4", cyc);
      check(cyc == 6, "R8", "skip4 done latency", cyc, 6);
      run_case('{5'd16, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0}, 0, "skip16", cyc);
      check(cyc == 18, "R8", "skip16 done latency", cyc, 18);

      // R10: start pulse during a run already covered in case1; rerun to confirm
      run_case(CASES[5], 1'b1, "case5_poke", cyc);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule